// File: doc/BRIEF.md
# Inter-Processor Doorbell Mailbox Bank

This block holds sixteen 32-bit doorbell words for a four-core cluster. Each core owns four of them. Any agent on the shared register bus can raise bits in a mailbox through its set window and drop bits through its clear window. Both windows read back the current mailbox value, so a receiving core can read a word, find its lowest raised bit, and clear exactly that bit.

Every mailbox drives a level request toward the core that owns it. The request stays active while the word holds any nonzero bit. A control word per core routes each of that core's four mailboxes to its normal interrupt line, to its fast interrupt line, or to neither. The fast route wins over the normal route. The block also exports a one-bit nonzero flag for every mailbox.

The bus is a single synchronous port. Writes take effect at the clock edge. Reads are combinational from the address.

Top module: `mbx_bank`

## Requirements
- R1: Reset, synchronous and active high, clears all sixteen mailboxes and all four control words. While these are zero, `core_irq`, `core_fiq` and `mbx_status` are all low.
- R2: A write to a set window ORs the ones of the written data into that mailbox. Bits written as zero keep their old value.
- R3: A write to a clear window drops exactly the bits written as one and keeps every other bit. Writing zero changes nothing.
- R4: A read of either the set window or the clear window of a mailbox returns that mailbox's current 32-bit contents.
- R5: `mbx_status[4*c+m]` is high exactly while mailbox m of core c holds a nonzero value.
- R6: Word addresses are decoded as follows. Set window of core c, mailbox m: 0x080 + 16*c + 4*m. Clear window: 0x0C0 + 16*c + 4*m. Control word of core c: 0x050 + 4*c. A write to one mailbox leaves every other mailbox unchanged.
- R7: In a control word, bits 3:0 are the normal-interrupt enables for mailboxes 0 to 3, and bits 7:4 are the fast-interrupt enables for mailboxes 0 to 3. A read returns these eight bits, with bits 31:8 read as zero.
- R8: `core_irq[c]` is high exactly when some mailbox m of core c is nonzero, has its normal enable set and has its fast enable clear.
- R9: `core_fiq[c]` is high exactly when some mailbox m of core c is nonzero and has its fast enable set, whatever its normal enable holds.
- R10: A set write followed in the next cycle by a clear write to the same mailbox applies both, in order. The same holds for a clear followed by a set.
- R11: A write to an unmapped or misaligned address changes no state, and a read of such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| core_irq | output | 4 | Normal mailbox interrupt level, one bit per core |
| core_fiq | output | 4 | Fast mailbox interrupt level, one bit per core |
| mbx_status | output | 16 | Nonzero flag per mailbox, index 4*core+mailbox |

## Verification
The assertions assume that only one agent drives the bus, so each cycle carries at most one write and a single write either sets or clears, never both. The bench drives the bus from one sequential thread on the falling edge and releases the write strobe before the next access, which keeps it within that assumption. The assertions also assume that reset is applied at the start. The bench holds reset for several cycles before the first access, and it later applies reset again in the middle of the run. Misaligned and unmapped addresses are driven on purpose, so that R11 is checked at the ports.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int NCORE  = 4;
    localparam int NBOX   = 4;
    localparam int DW     = 32;
    localparam int AW     = 8;
    localparam int NMBX   = NCORE * NBOX;
    localparam int IDX_W  = $clog2(NMBX);
    localparam int CTRL_W = 2 * NBOX;
    localparam int SPAN   = NMBX * 4;

    localparam int CTRL_BASE = 'h050;
    localparam int SET_BASE  = 'h080;
    localparam int CLR_BASE  = 'h0C0;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_SET,
        ACC_CLR,
        ACC_CTRL
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e        kind;
        logic [IDX_W-1:0] idx;
    } acc_t;

    function automatic acc_t decode_addr(input logic [AW-1:0] a);
        acc_t r;
        int   ai;
        int   off;
        ai     = int'(a);
        off    = 0;
        r.kind = ACC_NONE;
        r.idx  = '0;
        if (a[1:0] == 2'b00) begin
            if (ai >= SET_BASE && ai < SET_BASE + SPAN) begin
                r.kind = ACC_SET;
                off    = ai - SET_BASE;
            end else if (ai >= CLR_BASE && ai < CLR_BASE + SPAN) begin
                r.kind = ACC_CLR;
                off    = ai - CLR_BASE;
            end else if (ai >= CTRL_BASE && ai < CTRL_BASE + 4 * NCORE) begin
                r.kind = ACC_CTRL;
                off    = ai - CTRL_BASE;
            end
            r.idx = IDX_W'(off >> 2);
        end
        return r;
    endfunction

endpackage

// File: rtl/mbx_slot.sv
module mbx_slot
    import mbx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          set_en,
    input  logic          clr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] value,
    output logic          nonzero
);

    always_ff @(posedge clk) begin
        if (rst)
            value <= '0;
        else if (set_en)
            value <= value | wdata;
        else if (clr_en)
            value <= value & ~wdata;
    end

    assign nonzero = |value;

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> value == '0);

    p_set_raises_r2: assert property (@(posedge clk) disable iff (rst)
        set_en |=> ((value & $past(wdata)) == $past(wdata))
                && ((value & $past(value)) == $past(value)));

    p_clr_drops_r3: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> ((value & $past(wdata)) == '0)
                && ((value | $past(wdata)) == ($past(value) | $past(wdata))));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!set_en && !clr_en) |=> $stable(value));

endmodule

// File: rtl/mbx_core_gate.sv
module mbx_core_gate
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic [NBOX-1:0]   pend,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              irq,
    output logic              fiq
);

    logic [NBOX-1:0] ien;
    logic [NBOX-1:0] fen;

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (ctrl_we)
            ctrl_q <= ctrl_wdata;
    end

    assign ien = ctrl_q[NBOX-1:0];
    assign fen = ctrl_q[CTRL_W-1:NBOX];

    assign fiq = |(pend & fen);
    assign irq = |(pend & ien & ~fen);

    p_ctrl_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !ctrl_we |=> $stable(ctrl_q));

    p_irq_source_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> |(pend & ien));

    p_fiq_source_r9: assert property (@(posedge clk) disable iff (rst)
        fiq |-> |(pend & fen));

    p_fiq_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (&fen) |-> !irq);

endmodule

// File: rtl/mbx_rd_mux.sv
module mbx_rd_mux
    import mbx_pkg::*;
(
    input  acc_t                         acc,
    input  logic [NMBX-1:0][DW-1:0]      slot_val,
    input  logic [NCORE-1:0][CTRL_W-1:0] ctrl_val,
    output logic [DW-1:0]                rdata
);

    always_comb begin
        rdata = '0;
        unique case (acc.kind)
            ACC_SET, ACC_CLR: rdata = slot_val[acc.idx];
            ACC_CTRL: begin
                for (int c = 0; c < NCORE; c++) begin
                    if (acc.idx == IDX_W'(c))
                        rdata = {{(DW-CTRL_W){1'b0}}, ctrl_val[c]};
                end
            end
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/mbx_bank.sv
module mbx_bank
    import mbx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_wr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    output logic [NCORE-1:0] core_irq,
    output logic [NCORE-1:0] core_fiq,
    output logic [NMBX-1:0]  mbx_status
);

    acc_t                         acc;
    logic [NMBX-1:0]              set_en;
    logic [NMBX-1:0]              clr_en;
    logic [NCORE-1:0]             ctrl_we;
    logic [NMBX-1:0][DW-1:0]      slot_val;
    logic [NCORE-1:0][CTRL_W-1:0] ctrl_val;

    assign acc = decode_addr(bus_addr);

    for (genvar i = 0; i < NMBX; i++) begin : g_slot
        assign set_en[i] = bus_wr && (acc.kind == ACC_SET) && (acc.idx == IDX_W'(i));
        assign clr_en[i] = bus_wr && (acc.kind == ACC_CLR) && (acc.idx == IDX_W'(i));

        mbx_slot u_slot (
            .clk     (clk),
            .rst     (rst),
            .set_en  (set_en[i]),
            .clr_en  (clr_en[i]),
            .wdata   (bus_wdata),
            .value   (slot_val[i]),
            .nonzero (mbx_status[i])
        );
    end

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        assign ctrl_we[c] = bus_wr && (acc.kind == ACC_CTRL) && (acc.idx == IDX_W'(c));

        mbx_core_gate u_gate (
            .clk        (clk),
            .rst        (rst),
            .ctrl_we    (ctrl_we[c]),
            .ctrl_wdata (bus_wdata[CTRL_W-1:0]),
            .pend       (mbx_status[c*NBOX +: NBOX]),
            .ctrl_q     (ctrl_val[c]),
            .irq        (core_irq[c]),
            .fiq        (core_fiq[c])
        );
    end

    mbx_rd_mux u_rd (
        .acc      (acc),
        .slot_val (slot_val),
        .ctrl_val (ctrl_val),
        .rdata    (bus_rdata)
    );

    p_single_target_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({set_en, clr_en, ctrl_we}));

    p_no_write_no_change_r11: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(mbx_status));

endmodule

// File: tb/mbx_bank_tb_top.sv
`timescale 1ns/1ps
module mbx_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  core_irq;
    logic [3:0]  core_fiq;
    logic [15:0] mbx_status;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    mbx_bank dut_i (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .core_irq   (core_irq),
        .core_fiq   (core_fiq),
        .mbx_status (mbx_status)
    );

    typedef struct packed {
        logic        is_rd;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic [15:0] tag;
    } vec_t;

    localparam int NVEC = 18;
    localparam vec_t VEC [NVEC] = '{
        {1'b0, 8'h80, 32'h0000_0005, 32'h0,         "R2"},
        {1'b1, 8'hC0, 32'h0,         32'h0000_0005, "R4"},
        {1'b1, 8'h80, 32'h0,         32'h0000_0005, "R4"},
        {1'b0, 8'h80, 32'h0000_0102, 32'h0,         "R2"},
        {1'b1, 8'hC0, 32'h0,         32'h0000_0107, "R2"},
        {1'b0, 8'hC0, 32'h0000_0004, 32'h0,         "R3"},
        {1'b1, 8'h80, 32'h0,         32'h0000_0103, "R3"},
        {1'b0, 8'hC0, 32'h0000_0000, 32'h0,         "R3"},
        {1'b1, 8'hC0, 32'h0,         32'h0000_0103, "R3"},
        {1'b0, 8'hBC, 32'hFFFF_0000, 32'h0,         "R6"},
        {1'b1, 8'hFC, 32'h0,         32'hFFFF_0000, "R6"},
        {1'b1, 8'hC0, 32'h0,         32'h0000_0103, "R6"},
        {1'b0, 8'h94, 32'hA5A5_A5A5, 32'h0,         "R6"},
        {1'b1, 8'hD4, 32'h0,         32'hA5A5_A5A5, "R6"},
        {1'b0, 8'hD4, 32'hFFFF_FFFF, 32'h0,         "R3"},
        {1'b1, 8'h94, 32'h0,         32'h0000_0000, "R3"},
        {1'b0, 8'h5C, 32'hFFFF_FFA3, 32'h0,         "R7"},
        {1'b1, 8'h5C, 32'h0,         32'h0000_00A3, "R7"}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_wr   = 1'b0;
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check("R1 irq", {28'b0, core_irq}, 32'h0);
        check("R1 fiq", {28'b0, core_fiq}, 32'h0);
        check("R1 status", {16'b0, mbx_status}, 32'h0);
        rd_check("R1 mailbox", 8'hA8, 32'h0);
        rd_check("R1 ctrl", 8'h54, 32'h0);

        for (int k = 0; k < NVEC; k++) begin
            if (VEC[k].is_rd)
                rd_check($sformatf("%s vec%0d", VEC[k].tag, k), VEC[k].addr, VEC[k].exp);
            else
                wr(VEC[k].addr, VEC[k].wdata);
        end

        // R5: core0 mbx0 and core3 mbx3 are nonzero
        #1;
        check("R5 status", {16'b0, mbx_status}, 32'h0000_8001);
        // R9: core3 fast enable on mbx3 routes it to fiq
        check("R9 fiq", {28'b0, core_fiq}, 32'h8);
        check("R8 irq", {28'b0, core_irq}, 32'h0);

        wr(8'h50, 32'h01);
        check("R8 irq enable", {28'b0, core_irq}, 32'h1);
        wr(8'h50, 32'h11);
        check("R9 override irq", {28'b0, core_irq}, 32'h0);
        check("R9 override fiq", {28'b0, core_fiq}, 32'h9);
        wr(8'h50, 32'h02);
        check("R8 empty mbx", {28'b0, core_irq}, 32'h0);
        check("R9 fiq back", {28'b0, core_fiq}, 32'h8);

        // R10: set then clear in consecutive cycles (core2 mbx2)
        @(negedge clk);
        bus_addr = 8'hA8; bus_wdata = 32'hF0; bus_wr = 1'b1;
        @(negedge clk);
        bus_addr = 8'hE8; bus_wdata = 32'h30;
        @(negedge clk);
        bus_wr = 1'b0;
        rd_check("R10 set-clr", 8'hA8, 32'hC0);
        // R10: clear then set in consecutive cycles
        @(negedge clk);
        bus_addr = 8'hE8; bus_wdata = 32'hC0; bus_wr = 1'b1;
        @(negedge clk);
        bus_addr = 8'hA8; bus_wdata = 32'h40;
        @(negedge clk);
        bus_wr = 1'b0;
        rd_check("R10 clr-set", 8'hE8, 32'h40);

        // R11: unmapped and misaligned writes have no effect
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h60, 32'hFFFF_FFFF);
        wr(8'h82, 32'hFFFF_FFFF);
        wr(8'hC5, 32'hFFFF_FFFF);
        rd_check("R11 read unmapped", 8'h00, 32'h0);
        rd_check("R11 read misaligned", 8'h82, 32'h0);
        check("R11 status", {16'b0, mbx_status}, 32'h0000_8401);
        rd_check("R11 mbx intact", 8'hC0, 32'h103);
        rd_check("R11 ctrl intact", 8'h50, 32'h02);

        // R1: reset during operation
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 rerun status", {16'b0, mbx_status}, 32'h0);
        check("R1 rerun fiq", {28'b0, core_fiq}, 32'h0);
        rd_check("R1 rerun mbx", 8'hFC, 32'h0);
        rd_check("R1 rerun ctrl", 8'h5C, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule